// File: doc/BRIEF.md
# Open-Row-First Memory Request Picker

This block keeps a short ordered queue of pending memory requests, each tagged with a bank index and a row address. A memory controller feeds it two kinds of bank state. The first is the row currently latched in each bank, with a flag saying whether a row is latched at all. The second is the cycle at which each bank next becomes free. Alongside these it supplies the current cycle count. When the controller strobes `sel`, the block promotes one request to the head of the queue. The controller then issues the head request and removes it with `pop`. One instance serves either reads or writes, because the selection rule is the same for both.

Selection runs in one of two modes. In open-row-first mode the search covers every queued request at once. The oldest request that targets its bank's latched row wins over every other candidate. If no request hits a latched row, the oldest request whose bank is usable wins. A bank is usable when it is free now, or when it is one of the banks that become free soonest among those the queue refers to. In arrival-order mode the head is served as it stands. In both modes the requests that are not promoted keep their relative order.

A small controller tracks three states. `ST_EMPTY` means the queue holds nothing. `ST_WAIT` means the queue holds requests but none has been chosen since the last removal. `ST_PICKED` means the head was chosen by a select and may be issued. The transitions are:
- T_FILL: `ST_EMPTY` to `ST_WAIT` on an accepted push.
- T_CHOOSE: `ST_WAIT` to `ST_PICKED` on an accepted select.
- T_SERVE: `ST_PICKED` to `ST_WAIT` on a pop that leaves requests behind.
- T_DRAIN: `ST_WAIT` or `ST_PICKED` to `ST_EMPTY` on a pop of the last request.

All other accepted operations leave the state unchanged.

Top module: `dram_req_selector`

## Requirements
- R1: After reset the queue is empty: `no_req`=1, `head_ok`=0, `q_count`=0.
- R2: An accepted push appends (`push_bank`,`push_row`) at the tail, so requests leave in arrival order when no select intervenes. A push to a full queue (`q_count`=DEPTH) is ignored and the count stays at DEPTH.
- R3: A pop removes the head request and moves every remaining request one place toward the head. A pop on an empty queue has no effect.
- R4: With `fcfs_mode`=1, a select leaves the queue order unchanged.
- R5: With `fcfs_mode`=0, a select promotes the oldest request that hits a latched row. A request hits when bit b of `bank_row_open` is 1 and the row field at bits [b*ROW_W +: ROW_W] of `bank_open_row` equals the request's row, where b is the request's bank. A request to a bank whose open bit is 0 never hits.
- R6: A row hit is promoted even when an older request has a usable bank.
- R7: With no row hit, a select promotes the oldest request whose bank is usable. A bank is usable when its free time at bits [b*TIME_W +: TIME_W] of `bank_free_at` is at most `now`, or when the bank belongs to the earliest-free set (R8).
- R8: The earliest-free set holds every bank referenced by a queued request whose free time equals the minimum free time over all queued requests. Requests to banks that are neither free nor in this set are skipped.
- R9: A select never changes `q_count`. The requests that are not promoted keep their relative order behind the new head.
- R10: Only one operation takes effect per cycle. On a non-empty queue a pop overrides a select and a push, and a select overrides a push; the overridden operations are dropped. On an empty queue a push is accepted even when a pop or select is also asserted.
- R11: `head_ok` is 1 only in `ST_PICKED`. It rises in the cycle after an accepted select, stays high through pushes and further selects, and falls in the cycle after any accepted pop.
- R12: A select on an empty queue has no effect: `no_req` stays 1 and `head_ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fcfs_mode | input | 1 | 1 = serve in arrival order, 0 = open-row-first selection |
| push | input | 1 | Append a request at the tail |
| push_bank | input | BANK_W | Bank index of the pushed request |
| push_row | input | ROW_W | Row address of the pushed request |
| sel | input | 1 | Choose the next request and move it to the head |
| pop | input | 1 | Remove the head request |
| now | input | TIME_W | Current cycle count |
| bank_free_at | input | NBANK*TIME_W | Per-bank cycle at which the bank becomes free |
| bank_row_open | input | NBANK | Per-bank flag: a row is latched |
| bank_open_row | input | NBANK*ROW_W | Per-bank latched row address |
| no_req | output | 1 | Queue is empty |
| head_ok | output | 1 | Head was chosen by a select since the last pop |
| head_bank | output | BANK_W | Bank of the head request |
| head_row | output | ROW_W | Row of the head request |
| q_count | output | CNT_W | Number of queued requests |

## Verification
A wrong pick shows at `head_bank` and `head_row` in the cycle after the select, so the head is compared against an order model right then. A fault in the shift network that rebuilds the queue around the promoted entry does not touch the head. It shows only as a wrong request surfacing after one or more later pops, up to DEPTH pops away. For that reason the whole queue is drained and every request is compared in order after each select. A controller that reaches the wrong state shows on `head_ok` one cycle after the offending operation. A counter error shows on `q_count` and `no_req` at the same point.

// File: rtl/drq_pkg.sv
package drq_pkg;

    // controller states
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_PICKED = 2'd2
    } drq_state_e;

    // the single operation applied in a cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_SEL  = 2'd2,
        OP_POP  = 2'd3
    } drq_op_e;

endpackage

// File: rtl/drq_ctrl.sv
module drq_ctrl
    import drq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             sel_req,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] count,
    output drq_op_e          op,
    output logic             head_ok
);

    drq_state_e state_q, state_d;
    logic       empty, full, last_one;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign last_one = (count == CNT_W'(1));

    // operation priority: pop, then select, then push
    always_comb begin
        op = OP_NONE;
        if (pop_req && !empty)
            op = OP_POP;
        else if (sel_req && !empty)
            op = OP_SEL;
        else if (push_req && !full)
            op = OP_PUSH;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_PUSH)
                    state_d = ST_WAIT;              // T_FILL
            end
            ST_WAIT: begin
                if (op == OP_SEL)
                    state_d = ST_PICKED;            // T_CHOOSE
                else if (op == OP_POP && last_one)
                    state_d = ST_EMPTY;             // T_DRAIN
            end
            ST_PICKED: begin
                if (op == OP_POP)
                    state_d = last_one ? ST_EMPTY   // T_DRAIN
                                       : ST_WAIT;   // T_SERVE
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        head_ok = (state_q == ST_PICKED);
    end

endmodule

// File: rtl/drq_store.sv
module drq_store
    import drq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  drq_op_e                 op,
    input  logic                    reorder,
    input  logic [IDX_W-1:0]        pick_idx,
    input  logic [BANK_W-1:0]       push_bank,
    input  logic [ROW_W-1:0]        push_row,
    output logic [CNT_W-1:0]        count,
    output logic [DEPTH-1:0]        valid,
    output logic [DEPTH*BANK_W-1:0] bank_flat,
    output logic [DEPTH*ROW_W-1:0]  row_flat
);

    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
                row_q[i]  <= '0;
            end
        end else begin
            case (op)
                OP_POP: begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        bank_q[i] <= bank_q[i+1];
                        row_q[i]  <= row_q[i+1];
                    end
                    count <= count - 1'b1;
                end
                OP_SEL: begin
                    if (reorder) begin
                        bank_q[0] <= bank_q[pick_idx];
                        row_q[0]  <= row_q[pick_idx];
                        for (int i = 1; i < DEPTH; i++) begin
                            if (i <= int'(pick_idx)) begin
                                bank_q[i] <= bank_q[i-1];
                                row_q[i]  <= row_q[i-1];
                            end
                        end
                    end
                end
                OP_PUSH: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (i == int'(count)) begin
                            bank_q[i] <= push_bank;
                            row_q[i]  <= push_row;
                        end
                    end
                    count <= count + 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign valid[g]                       = (CNT_W'(g) < count);
        assign bank_flat[g*BANK_W +: BANK_W]  = bank_q[g];
        assign row_flat[g*ROW_W +: ROW_W]     = row_q[g];
    end

endmodule

// File: rtl/drq_earliest.sv
module drq_earliest #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int TIME_W = 16
) (
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH*BANK_W-1:0] bank_flat,
    input  logic [NBANK*TIME_W-1:0] free_flat,
    output logic [NBANK-1:0]        early_mask
);

    logic [BANK_W-1:0] ent_bank [DEPTH];
    logic [TIME_W-1:0] ent_free [DEPTH];
    logic [TIME_W-1:0] min_t;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign ent_bank[g] = bank_flat[g*BANK_W +: BANK_W];
        assign ent_free[g] = free_flat[int'(ent_bank[g])*TIME_W +: TIME_W];
    end

    // minimum free time over queued requests
    always_comb begin
        min_t = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid[i] && ent_free[i] < min_t)
                min_t = ent_free[i];
        end
    end

    // banks that reach that minimum
    always_comb begin
        early_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid[i] && ent_free[i] == min_t)
                early_mask[ent_bank[i]] = 1'b1;
        end
    end

endmodule

// File: rtl/drq_pick.sv
module drq_pick #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int TIME_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH*BANK_W-1:0] bank_flat,
    input  logic [DEPTH*ROW_W-1:0]  row_flat,
    input  logic [NBANK*ROW_W-1:0]  open_row_flat,
    input  logic [NBANK-1:0]        row_open,
    input  logic [NBANK*TIME_W-1:0] free_flat,
    input  logic [TIME_W-1:0]       now,
    input  logic [NBANK-1:0]        early_mask,
    output logic [IDX_W-1:0]        pick_idx
);

    logic [DEPTH-1:0] hit, ready;
    logic [IDX_W-1:0] hit_idx, rdy_idx;
    logic             any_hit, any_rdy;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cand
        logic [BANK_W-1:0] b;
        logic [ROW_W-1:0]  r;
        logic [TIME_W-1:0] ft;
        assign b  = bank_flat[g*BANK_W +: BANK_W];
        assign r  = row_flat[g*ROW_W +: ROW_W];
        assign ft = free_flat[int'(b)*TIME_W +: TIME_W];
        assign hit[g]   = valid[g] && row_open[b]
                          && (open_row_flat[int'(b)*ROW_W +: ROW_W] == r);
        assign ready[g] = valid[g] && ((ft <= now) || early_mask[b]);
    end

    // oldest candidate wins: scan youngest to oldest, last write stays
    always_comb begin
        hit_idx = '0;
        rdy_idx = '0;
        any_hit = 1'b0;
        any_rdy = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_idx = IDX_W'(i);
                any_hit = 1'b1;
            end
            if (ready[i]) begin
                rdy_idx = IDX_W'(i);
                any_rdy = 1'b1;
            end
        end
    end

    always_comb begin
        if (any_hit)
            pick_idx = hit_idx;
        else if (any_rdy)
            pick_idx = rdy_idx;
        else
            pick_idx = '0;
    end

endmodule

// File: rtl/dram_req_selector.sv
module dram_req_selector
    import drq_pkg::*;
#(
    parameter int  DEPTH  = 8,
    parameter int  NBANK  = 8,
    parameter int  ROW_W  = 14,
    parameter int  TIME_W = 16,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fcfs_mode,
    input  logic                    push,
    input  logic [BANK_W-1:0]       push_bank,
    input  logic [ROW_W-1:0]        push_row,
    input  logic                    sel,
    input  logic                    pop,
    input  logic [TIME_W-1:0]       now,
    input  logic [NBANK*TIME_W-1:0] bank_free_at,
    input  logic [NBANK-1:0]        bank_row_open,
    input  logic [NBANK*ROW_W-1:0]  bank_open_row,
    output logic                    no_req,
    output logic                    head_ok,
    output logic [BANK_W-1:0]       head_bank,
    output logic [ROW_W-1:0]        head_row,
    output logic [CNT_W-1:0]        q_count
);

    drq_op_e                 op;
    logic [DEPTH-1:0]        valid;
    logic [DEPTH*BANK_W-1:0] bank_flat;
    logic [DEPTH*ROW_W-1:0]  row_flat;
    logic [NBANK-1:0]        early_mask;
    logic [IDX_W-1:0]        pick_idx;

    drq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push),
        .sel_req  (sel),
        .pop_req  (pop),
        .count    (q_count),
        .op       (op),
        .head_ok  (head_ok)
    );

    drq_store #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .reorder   (!fcfs_mode),
        .pick_idx  (pick_idx),
        .push_bank (push_bank),
        .push_row  (push_row),
        .count     (q_count),
        .valid     (valid),
        .bank_flat (bank_flat),
        .row_flat  (row_flat)
    );

    drq_earliest #(
        .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .TIME_W(TIME_W)
    ) u_early (
        .valid      (valid),
        .bank_flat  (bank_flat),
        .free_flat  (bank_free_at),
        .early_mask (early_mask)
    );

    drq_pick #(
        .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .TIME_W(TIME_W), .IDX_W(IDX_W)
    ) u_pick (
        .valid         (valid),
        .bank_flat     (bank_flat),
        .row_flat      (row_flat),
        .open_row_flat (bank_open_row),
        .row_open      (bank_row_open),
        .free_flat     (bank_free_at),
        .now           (now),
        .early_mask    (early_mask),
        .pick_idx      (pick_idx)
    );

    assign no_req    = (q_count == '0);
    assign head_bank = bank_flat[BANK_W-1:0];
    assign head_row  = row_flat[ROW_W-1:0];

endmodule

// File: rtl/drq_chk.sv
module drq_chk #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              sel,
    input logic              pop,
    input logic              fcfs_mode,
    input logic              no_req,
    input logic              head_ok,
    input logic [BANK_W-1:0] head_bank,
    input logic [ROW_W-1:0]  head_row,
    input logic [CNT_W-1:0]  q_count
);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !sel && q_count < CNT_W'(DEPTH)
        |=> q_count == CNT_W'($past(q_count) + 1'b1));

    p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !no_req |=> q_count == CNT_W'($past(q_count) - 1'b1));

    p_fcfs_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel && fcfs_mode && !pop && !no_req
        |=> $stable(head_bank) && $stable(head_row));

    p_sel_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !pop && !no_req |=> $stable(q_count));

    p_headok_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        head_ok |-> !no_req);

    p_sel_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !pop && !no_req |=> head_ok);

    p_pop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !no_req |=> !head_ok);

    p_empty_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        no_req && !push |=> no_req && !head_ok);

endmodule

bind dram_req_selector drq_chk #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .sel       (sel),
    .pop       (pop),
    .fcfs_mode (fcfs_mode),
    .no_req    (no_req),
    .head_ok   (head_ok),
    .head_bank (head_bank),
    .head_row  (head_row),
    .q_count   (q_count)
);

// File: tb/sim_dram_req_selector.sv
`timescale 1ns/1ps
module sim_dram_req_selector;

    localparam int DEPTH  = 8;
    localparam int NBANK  = 8;
    localparam int ROW_W  = 14;
    localparam int TIME_W = 16;
    localparam int BANK_W = 3;
    localparam int CNT_W  = 4;
    localparam int NV     = 8;

    // vector table: mode(1=arrival order), count, 4 banks, 4 rows, now, expected pick, requirement
    // fixed bank state: open row of bank b = 10+b, bank 7 closed, free time of bank b = 2*b
    localparam int V_MODE [NV] = '{1, 0, 0, 0, 0, 0, 0, 0};
    localparam int V_N    [NV] = '{3, 3, 3, 4, 4, 3, 2, 3};
    localparam int V_BANK [NV*4] = '{3,2,1,0,  3,2,1,0,  1,5,4,0,  5,3,6,2,
                                     5,3,6,2,  2,4,6,0,  7,6,0,0,  4,5,1,0};
    localparam int V_ROW  [NV*4] = '{0,0,11,0, 0,0,11,0, 0,0,14,0, 0,0,0,0,
                                     0,0,0,0,  0,14,16,0, 17,0,0,0, 0,0,0,0};
    localparam int V_NOW  [NV] = '{0, 0, 3, 0, 7, 0, 0, 0};
    localparam int V_EXP  [NV] = '{0, 2, 2, 3, 1, 1, 1, 2};
    // R4 arrival order, R5 hit, R6 hit beats older ready, R8 earliest set,
    // R7 free bank, R5 oldest of two hits, R5 closed bank, R8 earliest set
    localparam int V_REQ  [NV] = '{4, 5, 6, 8, 7, 5, 5, 8};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    fcfs_mode = 1'b0;
    logic                    push = 1'b0;
    logic [BANK_W-1:0]       push_bank = '0;
    logic [ROW_W-1:0]        push_row = '0;
    logic                    sel = 1'b0;
    logic                    pop = 1'b0;
    logic [TIME_W-1:0]       now = '0;
    logic [NBANK*TIME_W-1:0] bank_free_at = '0;
    logic [NBANK-1:0]        bank_row_open = '0;
    logic [NBANK*ROW_W-1:0]  bank_open_row = '0;
    logic                    no_req, head_ok;
    logic [BANK_W-1:0]       head_bank;
    logic [ROW_W-1:0]        head_row;
    logic [CNT_W-1:0]        q_count;

    int pass_n = 0;
    int fail_n = 0;
    bit done = 1'b0;

    // model state
    int b_row [NBANK];
    int b_free [NBANK];
    int b_open [NBANK];
    int m_bank [DEPTH];
    int m_row [DEPTH];
    int m_mode;
    int m_now;

    always #2.5 clk = ~clk;

    dram_req_selector #(
        .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TIME_W(TIME_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode),
        .push(push), .push_bank(push_bank), .push_row(push_row),
        .sel(sel), .pop(pop), .now(now),
        .bank_free_at(bank_free_at), .bank_row_open(bank_row_open),
        .bank_open_row(bank_open_row),
        .no_req(no_req), .head_ok(head_ok), .head_bank(head_bank),
        .head_row(head_row), .q_count(q_count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        if (act == exp) begin
            pass_n++;
        end else begin
            fail_n++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_banks();
        for (int b = 0; b < NBANK; b++) begin
            bank_open_row[b*ROW_W +: ROW_W] = ROW_W'(b_row[b]);
            bank_free_at[b*TIME_W +: TIME_W] = TIME_W'(b_free[b]);
            bank_row_open[b] = (b_open[b] != 0);
        end
    endtask

    // reference choice from the requirements
    function automatic int ref_pick(int n);
        int mn;
        if (m_mode != 0) return 0;
        mn = 1 << 30;
        for (int i = 0; i < n; i++)
            if (b_free[m_bank[i]] < mn) mn = b_free[m_bank[i]];
        for (int i = 0; i < n; i++)
            if (b_open[m_bank[i]] != 0 && b_row[m_bank[i]] == m_row[i]) return i;
        for (int i = 0; i < n; i++)
            if (b_free[m_bank[i]] <= m_now || b_free[m_bank[i]] == mn) return i;
        return 0;
    endfunction

    task automatic push_one(int bk, int rw);
        push = 1'b1;
        push_bank = BANK_W'(bk);
        push_row = ROW_W'(rw);
        tick();
        push = 1'b0;
    endtask

    // fill with m_bank/m_row, select, then drain checking full order
    task automatic run_case(int n, string head_tag);
        int k;
        int ord [DEPTH];
        int p;
        for (int i = 0; i < n; i++) push_one(m_bank[i], m_row[i]);
        k = ref_pick(n);
        fcfs_mode = (m_mode != 0);
        now = TIME_W'(m_now);
        sel = 1'b1;
        tick();
        sel = 1'b0;
        chk(head_tag, {29'd0, head_bank} * 65536 + int'(head_row),
            m_bank[k] * 65536 + m_row[k]);
        chk("R11 head_ok after select", int'(head_ok), 1);
        chk("R9 count kept by select", int'(q_count), n);
        ord[0] = k;
        p = 1;
        for (int i = 0; i < n; i++)
            if (i != k) begin
                ord[p] = i;
                p++;
            end
        for (int j = 0; j < n; j++) begin
            chk("R9 drain order", {29'd0, head_bank} * 65536 + int'(head_row),
                m_bank[ord[j]] * 65536 + m_row[ord[j]]);
            pop = 1'b1;
            tick();
            pop = 1'b0;
        end
        chk("R3 empty after drain", int'(no_req), 1);
        fcfs_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fail_n++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", pass_n, pass_n + fail_n);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NBANK; b++) begin
            b_row[b] = 10 + b;
            b_free[b] = 2 * b;
            b_open[b] = (b == 7) ? 0 : 1;
        end
        load_banks();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 no_req", int'(no_req), 1);
        chk("R1 head_ok", int'(head_ok), 0);
        chk("R1 q_count", int'(q_count), 0);

        // R12 select on empty queue
        sel = 1'b1;
        tick();
        sel = 1'b0;
        chk("R12 no_req after empty select", int'(no_req), 1);
        chk("R12 head_ok after empty select", int'(head_ok), 0);

        // R3 pop on empty queue
        pop = 1'b1;
        tick();
        pop = 1'b0;
        chk("R3 count after empty pop", int'(q_count), 0);

        // table walk: R4 R5 R6 R7 R8 with R9 order checks
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 4; i++) begin
                m_bank[i] = V_BANK[v*4+i];
                m_row[i] = V_ROW[v*4+i];
            end
            m_mode = V_MODE[v];
            m_now = V_NOW[v];
            chk($sformatf("R%0d table pick %0d", V_REQ[v], v), ref_pick(V_N[v]), V_EXP[v]);
            run_case(V_N[v], $sformatf("R%0d table head %0d", V_REQ[v], v));
        end

        // R2 overfill and arrival order
        for (int i = 0; i < DEPTH + 1; i++) push_one(i % NBANK, 100 + i);
        chk("R2 count saturates", int'(q_count), DEPTH);
        chk("R11 head_ok low before select", int'(head_ok), 0);
        for (int j = 0; j < DEPTH; j++) begin
            chk("R2 arrival order", int'(head_row), 100 + j);
            pop = 1'b1;
            tick();
            pop = 1'b0;
        end
        chk("R2 dropped push absent", int'(no_req), 1);

        // R10 operation priority
        push_one(1, 50);
        push_one(2, 60);
        pop = 1'b1; sel = 1'b1; push = 1'b1; push_bank = 3'd3; push_row = 14'd70;
        tick();
        pop = 1'b0; sel = 1'b0; push = 1'b0;
        chk("R10 pop wins count", int'(q_count), 1);
        chk("R10 pop wins head", int'(head_row), 60);
        sel = 1'b1; push = 1'b1; push_bank = 3'd4; push_row = 14'd80;
        tick();
        sel = 1'b0; push = 1'b0;
        chk("R10 select wins count", int'(q_count), 1);
        chk("R11 head_ok after select", int'(head_ok), 1);
        push_one(4, 80);
        chk("R11 head_ok kept over push", int'(head_ok), 1);
        pop = 1'b1;
        tick();
        chk("R11 head_ok cleared by pop", int'(head_ok), 0);
        tick();
        pop = 1'b0;
        chk("R10 drained", int'(no_req), 1);
        // R10 push accepted on empty queue despite pop and select
        pop = 1'b1; sel = 1'b1; push = 1'b1; push_bank = 3'd5; push_row = 14'd90;
        tick();
        pop = 1'b0; sel = 1'b0; push = 1'b0;
        chk("R10 push on empty", int'(q_count), 1);
        pop = 1'b1;
        tick();
        pop = 1'b0;

        // random mixes against the order model (R5 R6 R7 R8 R9 R4)
        for (int t = 0; t < 300; t++) begin
            int n;
            for (int b = 0; b < NBANK; b++) begin
                b_row[b] = int'($urandom % 16);
                b_free[b] = int'($urandom % 16);
                b_open[b] = int'($urandom % 4 != 0);
            end
            load_banks();
            n = 1 + int'($urandom % DEPTH);
            for (int i = 0; i < n; i++) begin
                m_bank[i] = int'($urandom % NBANK);
                m_row[i] = ($urandom % 3 == 0) ? b_row[m_bank[i]] : int'($urandom % 16);
            end
            m_mode = ($urandom % 8 == 0) ? 1 : 0;
            m_now = int'($urandom % 16);
            run_case(n, "R7 random head");
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

endmodule